// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a synthesizable model of a single-clock static RAM with a registered read path and an internal four-word burst sequencer. Every synchronous input is captured on the rising clock edge. These inputs are the address, the write data, three chip enables, the byte-lane and whole-word write controls, two burst-start strobes and a burst-advance input. The strobe on the processor side always starts a read. The strobe on the controller side starts either a read or a write, depending on the write controls.

After a burst starts, each further clock with the advance input low steps a 2-bit counter. The counter forms the two low address bits, either in linear order or in XOR (interleaved) order. The data bus is split into a write-data input and a read-data output with a drive flag, so a tri-state pad can be placed around it. The output enable works asynchronously. After a deselect, the last read word stays on the bus for one extra cycle before the output is released.

Depth and word width are parameters. The default values are small enough for simulation.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is low and after it is released, `rdata_drv_o` is 0 and `rdata_o` is all zeros, and no burst is active until a strobe starts one.
- R2: When `strb_c_ni` is low at an edge N with all three chip enables active (`ce_a_ni`=0, `ce_b_i`=1, `ce_c_ni`=0) and no write requested, the word at `addr_i` is read. It appears on `rdata_o` after edge N+1, not after edge N.
- R3: With `mode_i`=0 at the burst start, access k (k=0..3) of a burst uses the start address with its two low bits replaced by (start low bits + k) mod 4. The upper bits are kept.
- R4: With `mode_i`=1 at the burst start, access k uses the start address with its two low bits replaced by (start low bits XOR k).
- R5: On an edge where a burst is active and neither strobe starts a new one, the burst count advances by one only if `adv_ni` is low. Otherwise the same address is accessed again.
- R6: With `gw_ni` high and `bwe_ni` low, lane i (bits i*LANE_W upward, LANE_W wide) is written only if `bw_ni[i]` is low, and the other lanes keep their contents. If `bwe_ni` is low and every `bw_ni` bit is high, the cycle is a read.
- R7: With `gw_ni` low, every lane is written, whatever the values of `bwe_ni` and `bw_ni`.
- R8: A `strb_p_ni` start is always a read, and the write controls are ignored on that edge. When both strobes are low, `strb_p_ni` wins, so the cycle is a read.
- R9: `strb_p_ni` is ignored while `ce_a_ni` is high. A running burst continues as if that strobe were not asserted.
- R10: A start attempt with any chip enable inactive deselects the block. Nothing is accessed, the burst ends, and later advance and write inputs have no effect until a new start.
- R11: If a deselect is registered at edge N, the last read word stays driven after edge N+1 and is released after edge N+2.
- R12: `rdata_drv_o` is 1 only while `oe_ni` is low (combinationally), a read word is loaded and the deselect hold has not run out. A registered write releases the bus at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, loaded at a burst start |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_drv_o | output | 1 | Drive enable for the data pads |
| ce_a_ni | input | 1 | Chip enable A, active low; also gates `strb_p_ni` |
| ce_b_i | input | 1 | Chip enable B, active high |
| ce_c_ni | input | 1 | Chip enable C, active low |
| strb_p_ni | input | 1 | Processor-side burst start, active low, read only |
| strb_c_ni | input | 1 | Controller-side burst start, active low |
| adv_ni | input | 1 | Burst advance, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | LANES | Per-lane write selects, active low |
| gw_ni | input | 1 | Whole-word write, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |

## Verification
The assertions check on every cycle how the input controls map onto the registered operation: a fully enabled processor-side start gives a read, a controller start with chip enable B low gives a deselect, a whole-word write gives a full lane mask, and the burst position holds when there is no advance. They also check the drive rules: no drive with the output enable high, release after a write, and release after two idle cycles. Only the bench scenarios can show that the data is right. This covers the burst address order in both modes, lanes that keep their old bytes, writes that are suppressed on a deselect or a processor-side start, the one-edge read latency, and the exact cycle in which a deselected word is released. The bench compares these against a cycle model of its own and against directed expectations.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int CNT_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ce_a_ni,
  input  logic              ce_b_i,
  input  logic              ce_c_ni,
  input  logic              strb_p_ni,
  input  logic              strb_c_ni,
  input  logic              adv_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              gw_ni,
  input  logic              mode_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              mode_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  mask_o
);
  logic              sel, proc_go, ctrl_go, wr_req;
  logic [LANES-1:0]  lane_sel;
  logic              active_q, mode_q;
  op_e               op_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;

  assign sel      = !ce_a_ni && ce_b_i && !ce_c_ni;
  assign proc_go  = !strb_p_ni && !ce_a_ni;
  assign ctrl_go  = !strb_c_ni;
  // whole-word write overrides the lane selects
  assign lane_sel = !gw_ni ? '1 : (!bwe_ni ? ~bw_ni : '0);
  assign wr_req   = |lane_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      op_q     <= OP_IDLE;
      base_q   <= '0;
      cnt_q    <= '0;
      mode_q   <= 1'b0;
      wdata_q  <= '0;
      mask_q   <= '0;
    end else begin
      wdata_q <= wdata_i;
      mask_q  <= lane_sel;
      if (proc_go || ctrl_go) begin
        if (sel) begin
          active_q <= 1'b1;
          base_q   <= addr_i;
          cnt_q    <= '0;
          mode_q   <= mode_i;
          op_q     <= (!proc_go && wr_req) ? OP_WR : OP_RD;
        end else begin
          active_q <= 1'b0;
          op_q     <= OP_IDLE;
        end
      end else if (active_q) begin
        if (!adv_ni) cnt_q <= cnt_q + 1'b1;
        op_q <= wr_req ? OP_WR : OP_RD;
      end else begin
        op_q <= OP_IDLE;
      end
    end
  end

  assign op_o    = op_q;
  assign base_o  = base_q;
  assign cnt_o   = cnt_q;
  assign mode_o  = mode_q;
  assign wdata_o = wdata_q;
  assign mask_o  = mask_q;

  a_r8_proc_start_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_p_ni && !ce_a_ni && ce_b_i && !ce_c_ni) |=> (op_q == OP_RD && cnt_q == '0));

  a_r10_ce_b_deselects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_c_ni && !ce_b_i) |=> (op_q == OP_IDLE && !active_q));

  a_r7_global_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gw_ni && !strb_c_ni && strb_p_ni && !ce_a_ni && ce_b_i && !ce_c_ni)
      |=> (op_q == OP_WR && (&mask_q)));

  a_r5_hold_without_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && strb_c_ni && (strb_p_ni || ce_a_ni) && adv_ni)
      |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [CNT_W-1:0] low;

  assign low = mode_i ? (base_i[CNT_W-1:0] ^ cnt_i) : (base_i[CNT_W-1:0] + cnt_i);

  generate
    if (ADDR_W > CNT_W) begin : g_wide
      assign addr_o = {base_i[ADDR_W-1:CNT_W], low};
    end else begin : g_narrow
      assign addr_o = low[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  mask_i,
  output logic [DATA_W-1:0] rdata_o
);
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk_i) begin
        if (op_i == OP_WR && mask_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
        if (op_i == OP_RD) rd_q <= mem[addr_i];
      end

      assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
    end
  endgenerate
endmodule

// File: rtl/sbs_drive.sv
module sbs_drive
  import sbs_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              drv_o
);
  localparam logic [1:0] HOLD_END = 2'd2;

  logic       live_q;
  logic [1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      idle_q <= HOLD_END;
    end else begin
      unique case (op_i)
        OP_RD: begin
          live_q <= 1'b1;
          idle_q <= '0;
        end
        OP_WR: live_q <= 1'b0;
        default: if (idle_q != HOLD_END) idle_q <= idle_q + 1'b1;
      endcase
    end
  end

  assign drv_o = !oe_ni && live_q && (idle_q != HOLD_END);
  assign dq_o  = drv_o ? rdata_i : '0;

  a_r12_oe_gates_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_o |-> !oe_ni);

  a_r12_write_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WR) |=> !drv_o);

  a_r11_release_after_two_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_IDLE) ##1 (op_i == OP_IDLE) |=> !drv_o);
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_drv_o,
  input  logic              ce_a_ni,
  input  logic              ce_b_i,
  input  logic              ce_c_ni,
  input  logic              strb_p_ni,
  input  logic              strb_c_ni,
  input  logic              adv_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              gw_ni,
  input  logic              oe_ni,
  input  logic              mode_i
);
  op_e               op;
  logic [ADDR_W-1:0] base, acc_addr;
  logic [CNT_W-1:0]  cnt;
  logic              mode;
  logic [DATA_W-1:0] wdata, rdata;
  logic [LANES-1:0]  mask;

  sbs_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .ce_a_ni, .ce_b_i, .ce_c_ni,
    .strb_p_ni, .strb_c_ni, .adv_ni, .bwe_ni, .bw_ni, .gw_ni, .mode_i,
    .op_o(op), .base_o(base), .cnt_o(cnt), .mode_o(mode), .wdata_o(wdata), .mask_o(mask)
  );

  sbs_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .base_i(base), .cnt_i(cnt), .mode_i(mode), .addr_o(acc_addr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .op_i(op), .addr_i(acc_addr), .wdata_i(wdata), .mask_i(mask), .rdata_o(rdata)
  );

  sbs_drive #(.DATA_W(DATA_W)) u_drive (
    .clk_i, .rst_ni, .op_i(op), .oe_ni, .rdata_i(rdata), .dq_o(rdata_o), .drv_o(rdata_drv_o)
  );
endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic drv;
  logic ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
  logic sp_n = 1'b1, sc_n = 1'b1, adv_n = 1'b1, bwe_n = 1'b1, gw_n = 1'b1, oe_n = 1'b0, mode = 1'b0;
  logic [LANES-1:0] bw_n = '1;

  int n_chk = 0, n_err = 0;

  always #(PERIOD/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rdata_drv_o(drv), .ce_a_ni(ce_a_n), .ce_b_i(ce_b), .ce_c_ni(ce_c_n),
    .strb_p_ni(sp_n), .strb_c_ni(sc_n), .adv_ni(adv_n), .bwe_ni(bwe_n), .bw_ni(bw_n),
    .gw_ni(gw_n), .oe_ni(oe_n), .mode_i(mode)
  );

  // cycle model: op 0 idle, 1 read, 2 write
  logic [DATA_W-1:0] m_mem [DEPTH];
  int                m_op = 0, m_idle = 2;
  logic              m_active = 1'b0, m_mode = 1'b0, m_live = 1'b0;
  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0]        m_cnt = '0;
  logic [DATA_W-1:0] m_wd = '0, m_dout = '0;
  logic [LANES-1:0]  m_mask = '0;

  function automatic logic [DATA_W-1:0] pat(int a);
    return DATA_W'(a * 1237 + 341) ^ DATA_W'(a << 9);
  endfunction

  function automatic logic [ADDR_W-1:0] baddr(logic [ADDR_W-1:0] b, logic [1:0] k, logic md);
    logic [1:0] lo;
    lo = md ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[ADDR_W-1:2], lo};
  endfunction

  task automatic chk(bit ok, string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [ADDR_W-1:0] a;
    logic [LANES-1:0]  ln;
    logic sel, pgo, cgo;
    a = baddr(m_base, m_cnt, m_mode);
    if (m_op == 2)
      for (int l = 0; l < LANES; l++)
        if (m_mask[l]) m_mem[a][l*LANE_W +: LANE_W] = m_wd[l*LANE_W +: LANE_W];
    if (m_op == 1) begin m_dout = m_mem[a]; m_live = 1'b1; m_idle = 0; end
    else if (m_op == 2) m_live = 1'b0;
    else if (m_idle < 2) m_idle++;
    sel = !ce_a_n && ce_b && !ce_c_n;
    pgo = !sp_n && !ce_a_n;
    cgo = !sc_n;
    ln  = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
    m_wd = wdata; m_mask = ln;
    if (pgo || cgo) begin
      if (sel) begin
        m_active = 1'b1; m_base = addr; m_cnt = '0; m_mode = mode;
        m_op = (!pgo && (|ln)) ? 2 : 1;
      end else begin m_active = 1'b0; m_op = 0; end
    end else if (m_active) begin
      if (!adv_n) m_cnt = m_cnt + 2'd1;
      m_op = (|ln) ? 2 : 1;
    end else m_op = 0;
  endtask

  task automatic compare(string tag);
    logic ed;
    ed = !oe_n && m_live && (m_idle < 2);
    chk(drv === ed, {tag, " drive"}, DATA_W'(drv), DATA_W'(ed));
    chk(rdata === (ed ? m_dout : '0), {tag, " data"}, rdata, ed ? m_dout : '0);
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    sp_n = 1'b1; sc_n = 1'b1; adv_n = 1'b1; bwe_n = 1'b1; bw_n = '1; gw_n = 1'b1;
    ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0; oe_n = 1'b0;
  endtask

  task automatic deselect(string tag);
    sc_n = 1'b0; ce_b = 1'b0; cyc(tag);
    quiet(); cyc(tag); cyc(tag);
  endtask

  task automatic start_rd(logic [ADDR_W-1:0] a, logic md, string tag);
    quiet(); addr = a; mode = md; sc_n = 1'b0; cyc(tag);
    sc_n = 1'b1;
  endtask

  task automatic rd_expect(string tag, logic [DATA_W-1:0] exp);
    chk(drv === 1'b1 && rdata === exp, tag, rdata, exp);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] last;
    void'($urandom(32'd4321));
    quiet();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(drv === 1'b0, "R1 reset drive", DATA_W'(drv), '0);
    chk(rdata === '0, "R1 reset data", rdata, '0);
    rst_n = 1'b1;
    cyc("R1 after reset");
    cyc("R1 after reset");

    // fill memory with whole-word write bursts
    for (int b = 0; b < DEPTH / 4; b++) begin
      quiet(); addr = ADDR_W'(b * 4); mode = 1'b0; gw_n = 1'b0; sc_n = 1'b0;
      wdata = pat(b * 4); cyc("R7 fill");
      sc_n = 1'b1; adv_n = 1'b0;
      for (int i = 1; i < 4; i++) begin wdata = pat(b * 4 + i); cyc("R7 fill"); end
    end
    quiet(); deselect("R10 after fill");

    // latency
    start_rd(8'h21, 1'b0, "R2 start");
    chk(drv === 1'b0, "R2 no data on start edge", DATA_W'(drv), '0);
    // linear order 21,22,23,20
    for (int i = 0; i < 4; i++) begin
      adv_n = (i < 3) ? 1'b0 : 1'b1;
      cyc("R3 linear");
      rd_expect("R3 linear order", pat(int'(baddr(8'h21, 2'(i), 1'b0))));
    end
    // double-cycle deselect
    last = rdata;
    sc_n = 1'b0; ce_b = 1'b0; cyc("R11 deselect edge");
    rd_expect("R11 data kept on deselect edge", pat(8'h20));
    quiet(); cyc("R11 hold");
    rd_expect("R11 held one more cycle", last);
    cyc("R11 release");
    chk(drv === 1'b0, "R11 released", DATA_W'(drv), '0);

    // interleaved order 45,44,47,46
    start_rd(8'h45, 1'b1, "R4 start");
    for (int i = 0; i < 4; i++) begin
      adv_n = (i < 3) ? 1'b0 : 1'b1;
      cyc("R4 interleaved");
      rd_expect("R4 interleaved order", pat(int'(baddr(8'h45, 2'(i), 1'b1))));
    end
    deselect("R10");

    // advance hold
    start_rd(8'h32, 1'b0, "R5 start");
    adv_n = 1'b1; cyc("R5");
    rd_expect("R5 first word", pat(8'h32));
    adv_n = 1'b0; cyc("R5");
    rd_expect("R5 no advance repeats", pat(8'h32));
    cyc("R5");
    rd_expect("R5 advance steps", pat(8'h33));
    deselect("R10");

    // byte write lane 0 only
    quiet(); addr = 8'h10; sc_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b10; wdata = '1; cyc("R6 byte write");
    quiet(); deselect("R6");
    // bwe with no lane selected is a read
    quiet(); addr = 8'h11; sc_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b11; wdata = '0; cyc("R6 no lane");
    quiet(); cyc("R6");
    rd_expect("R6 bwe without lanes reads", pat(8'h11));
    deselect("R6");
    start_rd(8'h10, 1'b0, "R6 readback");
    cyc("R6");
    rd_expect("R6 only lane 0 written", {pat(8'h10)[DATA_W-1:LANE_W], {LANE_W{1'b1}}});
    deselect("R6");

    // global write overrides lane controls
    quiet(); addr = 8'h12; sc_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1; bw_n = '1;
    wdata = 18'h2aaaa; cyc("R7 global");
    quiet(); deselect("R7");
    start_rd(8'h12, 1'b0, "R7 readback");
    cyc("R7");
    rd_expect("R7 all lanes written", 18'h2aaaa);
    deselect("R7");

    // processor strobe: read despite write request, and priority
    quiet(); addr = 8'h13; sp_n = 1'b0; gw_n = 1'b0; wdata = '0; cyc("R8 proc start");
    quiet(); cyc("R8");
    rd_expect("R8 proc start reads", pat(8'h13));
    deselect("R8");
    quiet(); addr = 8'h14; sp_n = 1'b0; sc_n = 1'b0; gw_n = 1'b0; wdata = '0; cyc("R8 both");
    quiet(); cyc("R8");
    rd_expect("R8 proc wins over ctrl", pat(8'h14));
    deselect("R8");
    start_rd(8'h13, 1'b0, "R8 readback");
    cyc("R8");
    rd_expect("R8 no write happened", pat(8'h13));
    deselect("R8");

    // processor strobe ignored with ce_a inactive
    start_rd(8'h50, 1'b0, "R9 start");
    sp_n = 1'b0; ce_a_n = 1'b1; adv_n = 1'b0; cyc("R9");
    rd_expect("R9 burst word 0", pat(8'h50));
    quiet(); cyc("R9");
    rd_expect("R9 burst continued", pat(8'h51));
    deselect("R9");

    // chip enable off: no write, no later effect
    quiet(); addr = 8'h60; sc_n = 1'b0; ce_c_n = 1'b1; gw_n = 1'b0; wdata = '0; cyc("R10 deselect");
    quiet(); gw_n = 1'b0; adv_n = 1'b0; wdata = '0; cyc("R10"); cyc("R10");
    chk(drv === 1'b0, "R10 idle no drive", DATA_W'(drv), '0);
    start_rd(8'h60, 1'b0, "R10 readback");
    cyc("R10");
    rd_expect("R10 memory untouched", pat(8'h60));
    deselect("R10");

    // output enable and write release
    start_rd(8'h70, 1'b0, "R12 start");
    oe_n = 1'b1; adv_n = 1'b0; cyc("R12 oe high");
    chk(drv === 1'b0 && rdata === '0, "R12 oe high blocks drive", rdata, '0);
    oe_n = 1'b0; #1;
    rd_expect("R12 oe low drives at once", pat(8'h70));
    gw_n = 1'b0; wdata = 18'h15a5a; cyc("R12 write");
    gw_n = 1'b1; adv_n = 1'b1; cyc("R12 write edge");
    chk(drv === 1'b0, "R12 write releases", DATA_W'(drv), '0);
    cyc("R12 read after write");
    rd_expect("R12 written word read", 18'h15a5a);
    deselect("R12");

    // constrained random against the model
    for (int i = 0; i < 3000; i++) begin
      addr   = ADDR_W'($urandom);
      wdata  = DATA_W'($urandom);
      ce_a_n = ($urandom % 8) == 0;
      ce_b   = ($urandom % 8) != 0;
      ce_c_n = ($urandom % 8) == 0;
      sp_n   = ($urandom % 6) != 0;
      sc_n   = ($urandom % 5) != 0;
      adv_n  = ($urandom % 3) == 0;
      bwe_n  = ($urandom % 2) == 0;
      bw_n   = LANES'($urandom);
      gw_n   = ($urandom % 4) != 0;
      oe_n   = ($urandom % 6) == 0;
      mode   = ($urandom % 2) == 0;
      cyc("R2 random");
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule